// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer that firmware controls through a 32-bit control word. It is kept alive through a separate service register that accepts a two-word key. Firmware sets an enable bit and picks one of four timeout lengths. It also picks what the block does when the count runs out: raise a normal interrupt, raise a fast interrupt, or request a system reset. To restart the count, firmware writes the first key and then the second key to the service register, with no other service write between them. The control bits that do not belong to the watchdog are stored and read back, and they have no other effect.

The block is built from two state machines and a counter. The key machine has the states `KEY_IDLE` and `KEY_ARMED`:
- A first-key write moves it from `KEY_IDLE` to `KEY_ARMED`.
- In `KEY_ARMED`, a second-key write completes the service and returns it to `KEY_IDLE`.
- In `KEY_ARMED`, a repeated first key keeps it in `KEY_ARMED`.
- In `KEY_ARMED`, any other service value returns it to `KEY_IDLE`.

The expiry machine has the states `ACT_WATCH`, `ACT_IRQ`, `ACT_FIQ` and `ACT_RST`:
- An expiry in `ACT_WATCH` moves it to `ACT_IRQ`, `ACT_FIQ` or `ACT_RST`, following the action code.
- `ACT_IRQ` and `ACT_FIQ` each return to `ACT_WATCH` only on a completed service.
- `ACT_RST` always returns to `ACT_WATCH` after one cycle.

Parameter `TMO_BASE` sets the base exponent of the timeout. It defaults to 24, and a bench can lower it to shorten runs.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the control word reads 0 and irq, fiq and rst_req are low. A write to offset 0x0 stores all 32 bits, and they read back unchanged on rdata while addr is 0x0.
- R2: Bit 24 of the control word enables the count. While bit 24 is 0 the counter is held at zero and nothing expires, so re-enabling starts a full timeout.
- R3: Bits 21:20 set the timeout L to 2^B, 2^(B+2), 2^(B+4) or 2^(B+5) clocks for codes 00, 01, 10 and 11, with B = TMO_BASE. The action output first goes high L rising edges after the edge that wrote the enable, or after the edge that completed a service.
- R4: With bits 23:22 = 00, an expiry sets irq, and irq stays high until a completed service.
- R5: With bits 23:22 = 01, an expiry sets fiq, and fiq stays high until a completed service.
- R6: With bits 23:22 = 10 or 11, an expiry drives rst_req high for exactly one cycle. The counter restarts from zero, so the next pulse follows L edges later.
- R7: A write of 0x123 and then a write of 0x321 to the service register (offset 0x4) completes a service. The completing edge restarts the count and clears a pending irq or fiq on that same edge.
- R8: The following do not complete a service: a 0x321 with no 0x123 before it, and a 0x123 followed by any other service value before the 0x321. A repeated 0x123 keeps the sequence armed, and writes to the control word between the two keys do not break it.
- R9: A service that completes on the same edge at which the count would expire wins. No action is raised, and the next expiry comes L edges after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte offset: 0x0 control word, 0x4 service register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Control word when addr is 0x0, otherwise zero |
| irq | output | 1 | Pending normal-interrupt expiry |
| fiq | output | 1 | Pending fast-interrupt expiry |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions check the following on every cycle:
- At most one of the three action outputs is high.
- A reset request never lasts past one cycle.
- A pending interrupt stays high until a service completes.
- Every expiry produces an action on the next cycle.
- The counter returns to zero after a disable or a service.
- Two services never complete back to back.

Some behaviour only the bench's scenarios can show:
- The exact expiry edge for each timeout code.
- The sequences of wrong, out-of-order and repeated keys.
- A service that lands on the same edge as an expiry.
- The restart after an enable is cleared.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int          DATA_W      = 32;
    localparam int          ADDR_W      = 4;
    localparam logic [3:0]  CTRL_OFS    = 4'h0;
    localparam logic [3:0]  SVC_OFS     = 4'h4;
    localparam logic [31:0] KEY_FIRST   = 32'h0000_0123;
    localparam logic [31:0] KEY_SECOND  = 32'h0000_0321;
    localparam int          EN_BIT      = 24;
    localparam int          ACT_LSB     = 22;
    localparam int          TMO_LSB     = 20;

    typedef enum logic {
        KEY_IDLE,
        KEY_ARMED
    } key_state_e;

    typedef enum logic [1:0] {
        ACT_WATCH,
        ACT_IRQ,
        ACT_FIQ,
        ACT_RST
    } act_state_e;

    typedef enum logic [1:0] {
        CODE_IRQ     = 2'b00,
        CODE_FIQ     = 2'b01,
        CODE_RST     = 2'b10,
        CODE_RST_ALT = 2'b11
    } act_code_e;

endpackage

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              svc_wr,
    input  logic [DATA_W-1:0] svc_data,
    output logic              svc_ok
);

    key_state_e state_q;
    key_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= KEY_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        svc_ok  = 1'b0;
        unique case (state_q)
            KEY_IDLE: begin
                if (svc_wr && svc_data == KEY_FIRST) begin
                    state_d = KEY_ARMED;
                end
            end
            KEY_ARMED: begin
                if (svc_wr) begin
                    if (svc_data == KEY_SECOND) begin
                        svc_ok  = 1'b1;
                        state_d = KEY_IDLE;
                    end else if (svc_data == KEY_FIRST) begin
                        state_d = KEY_ARMED;
                    end else begin
                        state_d = KEY_IDLE;
                    end
                end
            end
            default: state_d = KEY_IDLE;
        endcase
    end

    // R8
    key_no_double_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_ok |=> !svc_ok);

endmodule

// File: rtl/wdog_tick_counter.sv
module wdog_tick_counter #(
    parameter int TMO_BASE = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] tsel,
    input  logic       restart,
    output logic       expire
);

    localparam int CNT_W = TMO_BASE + 6;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit_m1;
    logic             at_end;
    int               span;

    always_comb begin
        unique case (tsel)
            2'b00:   span = TMO_BASE;
            2'b01:   span = TMO_BASE + 2;
            2'b10:   span = TMO_BASE + 4;
            default: span = TMO_BASE + 5;
        endcase
        limit_m1 = (CNT_W'(1) << span) - CNT_W'(1);
        at_end   = (cnt_q >= limit_m1);
        expire   = en && at_end && !restart;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || restart || at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R2
    cnt_held_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> cnt_q == '0);

    // R7
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && restart) |=> cnt_q == '0);

endmodule

// File: rtl/wdog_expiry_fsm.sv
module wdog_expiry_fsm
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       expire,
    input  logic [1:0] act_sel,
    input  logic       svc_ok,
    output logic       irq,
    output logic       fiq,
    output logic       rst_req
);

    act_state_e state_q;
    act_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACT_WATCH;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACT_WATCH: begin
                if (expire) begin
                    case (act_code_e'(act_sel))
                        CODE_IRQ: state_d = ACT_IRQ;
                        CODE_FIQ: state_d = ACT_FIQ;
                        default:  state_d = ACT_RST;
                    endcase
                end
            end
            ACT_IRQ, ACT_FIQ: begin
                if (svc_ok) begin
                    state_d = ACT_WATCH;
                end
            end
            ACT_RST: state_d = ACT_WATCH;
            default: state_d = ACT_WATCH;
        endcase
    end

    always_comb begin
        irq     = (state_q == ACT_IRQ);
        fiq     = (state_q == ACT_FIQ);
        rst_req = (state_q == ACT_RST);
    end

    // R6
    rst_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R4
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !svc_ok) |=> irq);

    // R5
    fiq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq && !svc_ok) |=> fiq);

    // R6
    one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq, fiq, rst_req}));

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
    import wdog_pkg::*;
#(
    parameter int TMO_BASE = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq,
    output logic        fiq,
    output logic        rst_req
);

    logic [DATA_W-1:0] ctrl_q;
    logic              ctrl_wr;
    logic              svc_wr;
    logic              svc_ok;
    logic              expire;

    assign ctrl_wr = wr_en && (addr == CTRL_OFS);
    assign svc_wr  = wr_en && (addr == SVC_OFS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= wdata;
        end
    end

    assign rdata = (addr == CTRL_OFS) ? ctrl_q : '0;

    wdog_key_seq u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .svc_wr   (svc_wr),
        .svc_data (wdata),
        .svc_ok   (svc_ok)
    );

    wdog_tick_counter #(.TMO_BASE(TMO_BASE)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctrl_q[EN_BIT]),
        .tsel    (ctrl_q[TMO_LSB +: 2]),
        .restart (svc_ok),
        .expire  (expire)
    );

    wdog_expiry_fsm u_act (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire),
        .act_sel (ctrl_q[ACT_LSB +: 2]),
        .svc_ok  (svc_ok),
        .irq     (irq),
        .fiq     (fiq),
        .rst_req (rst_req)
    );

    // R3
    expire_acts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (irq || fiq || rst_req));

    // R7
    svc_clears_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_ok |=> !(irq || fiq));

endmodule

// File: tb/tb_wdog_keyed.sv
`timescale 1ns/1ps
module tb_wdog_keyed;

    localparam int          TB_BASE = 3;
    localparam logic [3:0]  A_CTRL  = 4'h0;
    localparam logic [3:0]  A_SVC   = 4'h4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = A_CTRL;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq, rst_req;

    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdog_keyed #(.TMO_BASE(TB_BASE)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .fiq(fiq), .rst_req(rst_req)
    );

    function automatic int exp_len(input int tsel);
        case (tsel)
            0:       return 1 << TB_BASE;
            1:       return 1 << (TB_BASE + 2);
            2:       return 1 << (TB_BASE + 4);
            default: return 1 << (TB_BASE + 5);
        endcase
    endfunction

    function automatic logic [2:0] exp_out(input int act);
        case (act)
            0:       return 3'b100;
            1:       return 3'b010;
            default: return 3'b001;
        endcase
    endfunction

    function automatic logic [31:0] ctrl_word(input bit en, input int act, input int tsel,
                                              input logic [31:0] other);
        logic [31:0] w;
        w = other & ~32'h01F0_0000;
        w[24] = en;
        w[23:22] = act[1:0];
        w[21:20] = tsel[1:0];
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] expv);
        n_chk++;
        if (got !== expv) begin
            n_err++;
            $display("FAIL %s: got %h expected %h (cycle %0d)", req, got, expv, cyc);
        end
    endtask

    // Called at a negedge; the write takes effect at the next posedge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        addr  = A_CTRL;
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic service();
        wr(A_SVC, 32'h123);
        wr(A_SVC, 32'h321);
    endtask

    // One expiry scenario; d < 0 means no service before the expiry.
    task automatic run_expiry(input int act, input int tsel, input int d, input string req);
        int l, ref_c;
        logic [31:0] w;
        l = exp_len(tsel);
        w = ctrl_word(1'b1, act, tsel, $urandom);
        wr(A_CTRL, w);
        ref_c = cyc;
        chk("R1 readback", rdata, w);
        if (d >= 0) begin
            wait_cyc(ref_c + d);
            service();
            ref_c = cyc;
        end
        wait_cyc(ref_c + l - 1);
        chk({req, " R3 before expiry"}, {29'd0, irq, fiq, rst_req}, 32'd0);
        wait_cyc(ref_c + l);
        chk({req, " R3 at expiry"}, {29'd0, irq, fiq, rst_req}, {29'd0, exp_out(act)});
        if (act >= 2) begin
            wait_cyc(ref_c + l + 1);
            chk("R6 pulse width", {29'd0, irq, fiq, rst_req}, 32'd0);
        end else begin
            wait_cyc(ref_c + l + 5);
            chk({req, " pending held"}, {29'd0, irq, fiq, rst_req}, {29'd0, exp_out(act)});
            service();
            chk("R7 service clears pending", {29'd0, irq, fiq, rst_req}, 32'd0);
        end
        wr(A_CTRL, 32'd0);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        int w0, l, s;
        logic [31:0] w;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 reset ctrl", rdata, 32'd0);
        chk("R1 reset outputs", {29'd0, irq, fiq, rst_req}, 32'd0);

        // R1 / R2: all bits stored, disabled watchdog never fires
        w = ctrl_word(1'b0, 0, 0, 32'hDEAD_BEEF) | 32'h00F0_0000;
        wr(A_CTRL, w);
        chk("R1 readback all bits", rdata, w);
        addr = A_SVC;
        #1 chk("R1 other offset reads zero", rdata, 32'd0);
        addr = A_CTRL;
        repeat (300) @(negedge clk);
        chk("R2 disabled no expiry", {29'd0, irq, fiq, rst_req}, 32'd0);

        // R3 / R4 / R5 / R6: every action and timeout code
        for (int a = 0; a < 4; a++) begin
            for (int t = 0; t < 4; t++) begin
                run_expiry(a, t, -1, (a == 0) ? "R4" : (a == 1) ? "R5" : "R6");
            end
        end

        // R6: second reset pulse after a full timeout
        wr(A_CTRL, ctrl_word(1'b1, 2, 0, 32'd0));
        w0 = cyc;
        l = exp_len(0);
        wait_cyc(w0 + l);
        chk("R6 first pulse", {31'd0, rst_req}, 32'd1);
        wait_cyc(w0 + 2 * l - 1);
        chk("R6 before second pulse", {31'd0, rst_req}, 32'd0);
        wait_cyc(w0 + 2 * l);
        chk("R6 second pulse", {31'd0, rst_req}, 32'd1);
        wr(A_CTRL, 32'd0);

        // R2: clearing enable clears the count
        wr(A_CTRL, ctrl_word(1'b1, 0, 0, 32'd0));
        w0 = cyc;
        wait_cyc(w0 + 5);
        wr(A_CTRL, ctrl_word(1'b0, 0, 0, 32'd0));
        repeat (4) @(negedge clk);
        wr(A_CTRL, ctrl_word(1'b1, 0, 0, 32'd0));
        w0 = cyc;
        wait_cyc(w0 + exp_len(0) - 1);
        chk("R2 re-enable restarts", {31'd0, irq}, 32'd0);
        wait_cyc(w0 + exp_len(0));
        chk("R2 expiry after re-enable", {31'd0, irq}, 32'd1);
        service();
        wr(A_CTRL, 32'd0);

        // R8: broken sequences do not restart the count
        wr(A_CTRL, ctrl_word(1'b1, 0, 2, 32'd0));
        w0 = cyc;
        l = exp_len(2);
        wr(A_SVC, 32'h321);
        wr(A_SVC, 32'h123);
        wr(A_SVC, 32'h555);
        wr(A_SVC, 32'h321);
        wr(A_SVC, 32'h321);
        wait_cyc(w0 + l - 1);
        chk("R8 bad keys ignored (before)", {31'd0, irq}, 32'd0);
        wait_cyc(w0 + l);
        chk("R8 bad keys ignored (expiry)", {31'd0, irq}, 32'd1);
        // R8: control writes between keys keep the sequence
        wr(A_SVC, 32'h123);
        wr(A_CTRL, ctrl_word(1'b1, 0, 2, 32'd0));
        wr(A_SVC, 32'h321);
        chk("R8 ctrl write between keys", {31'd0, irq}, 32'd0);
        wr(A_CTRL, 32'd0);

        // R8: repeated first key stays armed
        wr(A_CTRL, ctrl_word(1'b1, 1, 1, 32'd0));
        w0 = cyc;
        l = exp_len(1);
        wait_cyc(w0 + 10);
        wr(A_SVC, 32'h123);
        wr(A_SVC, 32'h123);
        wr(A_SVC, 32'h321);
        s = cyc;
        wait_cyc(s + l - 1);
        chk("R8 repeated first key restarts", {31'd0, fiq}, 32'd0);
        wait_cyc(s + l);
        chk("R8 expiry after repeated key", {31'd0, fiq}, 32'd1);
        service();
        wr(A_CTRL, 32'd0);

        // R9: service on the expiry edge wins
        wr(A_CTRL, ctrl_word(1'b1, 0, 1, 32'd0));
        w0 = cyc;
        l = exp_len(1);
        wait_cyc(w0 + l - 2);
        service();
        chk("R9 no expiry on service edge", {29'd0, irq, fiq, rst_req}, 32'd0);
        wait_cyc(w0 + 2 * l - 1);
        chk("R9 before next expiry", {31'd0, irq}, 32'd0);
        wait_cyc(w0 + 2 * l);
        chk("R9 next expiry", {31'd0, irq}, 32'd1);
        service();
        wr(A_CTRL, 32'd0);

        // R7: random actions, timeouts and service points
        for (int i = 0; i < 24; i++) begin
            int a, t, d;
            a = int'($urandom % 4);
            t = int'($urandom % 4);
            d = ($urandom % 2 == 0) ? -1 : int'($urandom % (exp_len(t) - 2));
            run_expiry(a, t, d, "R7 random");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule